// File: doc/BRIEF.md
# Multiplexed Bus Register Interface

This block is the control-side peripheral port of a line modem. A host processor reaches it over an 8-bit multiplexed address/data bus. An address strobe (`ale`) carries the register address and the chip-select level, and both are captured on the strobe's falling edge. Separate active-low read and write strobes then move one byte. Behind the port are a small register file, a read-only detect register and a fixed identity code. The register file holds two control registers and a tone register, and the rest of the modem reads them as plain outputs. The detect register follows the condition flags from the modem's detectors.

A rising transition on any detect flag latches an interrupt request. When the interrupt-enable bit in the second control register is set, the active-low `irq_n` output shows that request. The request stays pending until the host reads the detect register, and it is released when that read strobe ends. All strobes are sampled on the block's system clock, and their edges are found by comparing each strobe with its value on the previous clock.

Top module: `modem_bus_regs`

## Requirements
- R1: On the clock that first sees `ale` low after it was high, the block captures `ad_in[2:0]` as the address and `cs_n` as the select level. Later changes of `ad_in` or `cs_n` do not change which register a following read or write uses.
- R2: Address 000 is control register A, address 001 is control register B and address 011 is the tone register. Each is written with a full byte, reads back the value written, and drives that value on `cr0_o`, `cr1_o` or `tone_o`.
- R3: `ad_oe` is 1 only while `rd_n` is low and the latched select level is low. Whenever `ad_oe` is 0, `ad_out` is 0x00.
- R4: A register is written with the `ad_in` value present on the clock that sees `wr_n` rise. No register changes when the latched select level is high.
- R5: Address 010 reads the detect register, which is `det_in` as registered on the previous clock. A write to address 010 has no effect.
- R6: Address 110 reads the constant `ID_CODE` (default 0x3B). A write to address 110 has no effect.
- R7: A read of address 100, 101 or 111 returns 0x00. A write to any of these addresses leaves all three writable registers unchanged.
- R8: A 0-to-1 transition on any bit of `det_in` sets the interrupt pending latch. A flag that stays high sets it only once. `irq_n` is low exactly when the latch is set and bit 5 of control register B is 1.
- R9: The pending latch is cleared on the clock that sees `rd_n` rise at the end of a selected read of address 010. A read of any other register does not clear it. If a new flag rises on that same clock, the latch stays set.
- R10: While `rst_n` is low, the control registers, the tone register and the pending latch are cleared, `irq_n` is 1 and `ad_oe` is 0.
- R11: The pending latch is set even while bit 5 of control register B is 0. Setting that bit later drives `irq_n` low for a request that is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; its falling edge captures address and select |
| cs_n | input | 1 | Active-low chip select, captured with the address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; data is taken on its rising edge |
| ad_in | input | DATA_W | Address/data bus as seen by the block |
| ad_out | output | DATA_W | Read data; 0x00 when not driving |
| ad_oe | output | 1 | Output enable for the tri-state bus driver |
| det_in | input | DATA_W | Condition flags from the modem's detectors |
| cr0_o | output | DATA_W | Control register A contents |
| cr1_o | output | DATA_W | Control register B contents; bit 5 enables the interrupt |
| tone_o | output | DATA_W | Tone register contents |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench changes the bus lines and `cs_n` right after the address strobe falls. A design that decoded the live bus instead of the captured address would write the wrong register and fail the tone and control-B checks. It makes writes and reads with the select latched high, writes to the detect, identity and unmapped addresses, and reads of unmapped addresses. A design with a missing select gate or a loose decode would corrupt a register or drive the bus. The interrupt sequence raises a flag while interrupts are disabled and enables them afterwards. It reads another register while a request is pending, and it holds a flag high after the detect register has been read. A latch that is level-sensitive, cleared too early, cleared by the wrong address or gated at set time would show the wrong `irq_n` level.

// File: rtl/modem_bus_pkg.sv
package modem_bus_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_RW = 3;

  localparam logic [ADDR_W-1:0] SEL_CTRL_A = 3'b000;
  localparam logic [ADDR_W-1:0] SEL_CTRL_B = 3'b001;
  localparam logic [ADDR_W-1:0] SEL_DETECT = 3'b010;
  localparam logic [ADDR_W-1:0] SEL_TONE   = 3'b011;
  localparam logic [ADDR_W-1:0] SEL_IDENT  = 3'b110;

  // Addresses of the host-writable registers, index order matches rw_q.
  localparam logic [ADDR_W-1:0] RW_ADDR [NUM_RW] = '{SEL_CTRL_A, SEL_CTRL_B, SEL_TONE};
endpackage

// File: rtl/bus_strobe_capture.sv
module bus_strobe_capture
  import modem_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_q,
  output logic              rd_rise,
  output logic              wr_rise
);
  logic              ale_prev, ale_prev_d;
  logic              rd_prev, rd_prev_d;
  logic              wr_prev, wr_prev_d;
  logic [ADDR_W-1:0] addr_d;
  logic              sel_d;
  logic              ale_fall;

  assign ale_fall = ale_prev & ~ale;
  assign rd_rise  = ~rd_prev & rd_n;
  assign wr_rise  = ~wr_prev & wr_n;

  always_comb begin
    ale_prev_d = ale;
    rd_prev_d  = rd_n;
    wr_prev_d  = wr_n;
    addr_d     = addr_q;
    sel_d      = sel_q;
    if (ale_fall) begin
      addr_d = addr_in;
      sel_d  = ~cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_prev <= 1'b0;
      rd_prev  <= 1'b1;
      wr_prev  <= 1'b1;
      addr_q   <= '0;
      sel_q    <= 1'b0;
    end else begin
      ale_prev <= ale_prev_d;
      rd_prev  <= rd_prev_d;
      wr_prev  <= wr_prev_d;
      addr_q   <= addr_d;
      sel_q    <= sel_d;
    end
  end
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
  import modem_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rw_q [NUM_RW]
);
  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = RW_ADDR[g];
    logic              hit;
    logic [DATA_W-1:0] val_q, val_d;

    assign hit = wr_stb && (addr == MY_ADDR);

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign rw_q[g] = val_q;
  end
endmodule

// File: rtl/detect_irq.sv
module detect_irq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] det_in,
  input  logic              irq_en,
  input  logic              clr_stb,
  output logic [DATA_W-1:0] det_q,
  output logic              det_rise_any,
  output logic              pend_q,
  output logic              irq_n
);
  logic [DATA_W-1:0] det_d;
  logic              pend_d;

  assign det_rise_any = |(det_in & ~det_q);

  always_comb begin
    det_d  = det_in;
    pend_d = pend_q;
    if (clr_stb)      pend_d = 1'b0;
    if (det_rise_any) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      det_q  <= det_d;
      pend_q <= pend_d;
    end
  end

  assign irq_n = ~(pend_q & irq_en);
endmodule

// File: rtl/modem_bus_regs.sv
module modem_bus_regs
  import modem_bus_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] ID_CODE    = 8'h3B,
  parameter int                IRQ_EN_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] det_in,
  output logic [DATA_W-1:0] cr0_o,
  output logic [DATA_W-1:0] cr1_o,
  output logic [DATA_W-1:0] tone_o,
  output logic              irq_n
);
  logic [ADDR_W-1:0] addr_q;
  logic              sel_q, rd_rise, wr_rise;
  logic              wr_stb, clr_stb;
  logic [DATA_W-1:0] rw_q [NUM_RW];
  logic [DATA_W-1:0] det_q;
  logic              det_rise_any, irq_pend;
  logic [DATA_W-1:0] rd_mux;

  bus_strobe_capture u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_in (ad_in[ADDR_W-1:0]),
    .addr_q  (addr_q),
    .sel_q   (sel_q),
    .rd_rise (rd_rise),
    .wr_rise (wr_rise)
  );

  assign wr_stb  = wr_rise & sel_q;
  assign clr_stb = rd_rise & sel_q & (addr_q == SEL_DETECT);

  ctrl_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .addr   (addr_q),
    .wdata  (ad_in),
    .rw_q   (rw_q)
  );

  assign cr0_o  = rw_q[0];
  assign cr1_o  = rw_q[1];
  assign tone_o = rw_q[2];

  detect_irq #(.DATA_W(DATA_W)) u_det (
    .clk          (clk),
    .rst_n        (rst_n),
    .det_in       (det_in),
    .irq_en       (rw_q[1][IRQ_EN_BIT]),
    .clr_stb      (clr_stb),
    .det_q        (det_q),
    .det_rise_any (det_rise_any),
    .pend_q       (irq_pend),
    .irq_n        (irq_n)
  );

  always_comb begin
    case (addr_q)
      SEL_CTRL_A: rd_mux = rw_q[0];
      SEL_CTRL_B: rd_mux = rw_q[1];
      SEL_DETECT: rd_mux = det_q;
      SEL_TONE:   rd_mux = rw_q[2];
      SEL_IDENT:  rd_mux = ID_CODE;
      default:    rd_mux = '0;
    endcase
  end

  assign ad_oe  = ~rd_n & sel_q;
  assign ad_out = ad_oe ? rd_mux : '0;
endmodule

// File: rtl/modem_bus_regs_chk.sv
module modem_bus_regs_chk
  import modem_bus_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int IRQ_EN_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic [DATA_W-1:0] cr0_o,
  input logic [DATA_W-1:0] cr1_o,
  input logic [DATA_W-1:0] tone_o,
  input logic              irq_n,
  input logic [ADDR_W-1:0] addr_q,
  input logic              sel_q,
  input logic              det_rise_any,
  input logic              irq_pend
);
  // R3: an idle bus carries zero
  a_r3_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> (ad_out == '0));

  // R3: the driver is never on while the read strobe is high
  a_r3_drive_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !rd_n);

  // R4: without a write-strobe rise no writable register moves
  a_r4_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(wr_n) |=> ($stable(cr0_o) && $stable(cr1_o) && $stable(tone_o)));

  // R8: a rising flag leaves the request pending
  a_r8_rise_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    det_rise_any |=> irq_pend);

  // R8: interrupt only with the enable bit
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> cr1_o[IRQ_EN_BIT]);

  // R9: end of a selected detect read with no new flag releases the line
  a_r9_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) && sel_q && (addr_q == SEL_DETECT) && !det_rise_any) |=> irq_n);
endmodule

bind modem_bus_regs modem_bus_regs_chk #(.DATA_W(DATA_W), .IRQ_EN_BIT(IRQ_EN_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_n         (rd_n),
  .wr_n         (wr_n),
  .ad_oe        (ad_oe),
  .ad_out       (ad_out),
  .cr0_o        (cr0_o),
  .cr1_o        (cr1_o),
  .tone_o       (tone_o),
  .irq_n        (irq_n),
  .addr_q       (addr_q),
  .sel_q        (sel_q),
  .det_rise_any (det_rise_any),
  .irq_pend     (irq_pend)
);

// File: tb/modem_bus_regs_tb_top.sv
module modem_bus_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00, det_in = 8'h00;
  logic [7:0] ad_out, cr0_o, cr1_o, tone_o;
  logic       ad_oe, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic smp = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  modem_bus_regs dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .det_in(det_in),
    .cr0_o(cr0_o), .cr1_o(cr1_o), .tone_o(tone_o), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected bus state and compares {ad_oe, ad_out}
  always @(posedge smp) begin
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: sample with empty queue, actual 0x%0h expected none", {ad_oe, ad_out});
    end else begin
      check(tag_q.pop_front(), {ad_oe, ad_out}, exp_q.pop_front());
    end
  end

  task automatic latch(input logic [2:0] a, input logic c);
    @(negedge clk); ale = 1'b1; ad_in = {5'b0, a}; cs_n = c;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic c, input logic [7:0] d);
    latch(a, c);
    ad_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); ad_in = 8'hEE;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic c, input logic [8:0] e, input string tag);
    latch(a, c);
    ad_in = 8'hC3; rd_n = 1'b0;
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    #1 smp = 1'b1; #1 smp = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 cr0", {1'b0, cr0_o}, 9'h000);
    check("R10 cr1", {1'b0, cr1_o}, 9'h000);
    check("R10 tone", {1'b0, tone_o}, 9'h000);
    check("R10 irq_n/oe", {7'b0, irq_n, ad_oe}, 9'h002);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write and read back
    bus_wr(3'b000, 1'b0, 8'h3C);
    bus_wr(3'b001, 1'b0, 8'h81);
    bus_wr(3'b011, 1'b0, 8'h5A);
    check("R2 cr0_o", {1'b0, cr0_o}, 9'h03C);
    check("R2 cr1_o", {1'b0, cr1_o}, 9'h081);
    check("R2 tone_o", {1'b0, tone_o}, 9'h05A);
    bus_rd(3'b000, 1'b0, 9'h13C, "R2 read ctrl A");
    bus_rd(3'b001, 1'b0, 9'h181, "R2 read ctrl B");
    bus_rd(3'b011, 1'b0, 9'h15A, "R2 read tone");

    // R4/R3: deselected write and read
    bus_wr(3'b000, 1'b1, 8'hFF);
    check("R4 deselected write", {1'b0, cr0_o}, 9'h03C);
    bus_rd(3'b000, 1'b1, 9'h000, "R3 deselected read no drive");

    // R1: address and select held from the strobe fall
    latch(3'b011, 1'b0);
    cs_n = 1'b1; ad_in = 8'h99; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); ad_in = 8'hEE;
    check("R1 tone took data", {1'b0, tone_o}, 9'h099);
    check("R1 ctrl B untouched", {1'b0, cr1_o}, 9'h081);

    // R7: unmapped
    bus_rd(3'b100, 1'b0, 9'h100, "R7 read 100");
    bus_rd(3'b101, 1'b0, 9'h100, "R7 read 101");
    bus_rd(3'b111, 1'b0, 9'h100, "R7 read 111");
    bus_wr(3'b101, 1'b0, 8'hFF);
    check("R7 regs after unmapped write", {1'b0, cr0_o ^ cr1_o ^ tone_o}, {1'b0, 8'h3C ^ 8'h81 ^ 8'h99});

    // R6: identity
    bus_rd(3'b110, 1'b0, 9'h13B, "R6 read id");
    bus_wr(3'b110, 1'b0, 8'h00);
    bus_rd(3'b110, 1'b0, 9'h13B, "R6 id after write");

    // R11: pending while disabled, shown once enabled
    @(negedge clk); det_in = 8'h05;
    @(negedge clk);
    check("R11 disabled irq_n high", {8'b0, irq_n}, 9'h001);
    bus_wr(3'b001, 1'b0, 8'h20);
    check("R11 enable shows pending", {8'b0, irq_n}, 9'h000);

    // R9/R5: detect read releases at end of strobe
    latch(3'b010, 1'b0);
    rd_n = 1'b0;
    @(negedge clk);
    exp_q.push_back(9'h105); tag_q.push_back("R5 read detect");
    #1 smp = 1'b1; #1 smp = 1'b0;
    check("R9 held during read", {8'b0, irq_n}, 9'h000);
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    check("R9 released after read", {8'b0, irq_n}, 9'h001);

    // R5: write to detect ignored
    bus_wr(3'b010, 1'b0, 8'hFF);
    bus_rd(3'b010, 1'b0, 9'h105, "R5 detect after write");

    // R8: new flag rise
    det_in = 8'h07;
    @(negedge clk);
    check("R8 new flag sets irq", {8'b0, irq_n}, 9'h000);
    bus_rd(3'b000, 1'b0, 9'h13C, "R9 other read");
    check("R9 other read keeps irq", {8'b0, irq_n}, 9'h000);
    bus_rd(3'b010, 1'b0, 9'h107, "R8 read detect");
    check("R8 cleared", {8'b0, irq_n}, 9'h001);
    repeat (3) @(negedge clk);
    check("R8 held flag no re-raise", {8'b0, irq_n}, 9'h001);
    det_in = 8'h00;
    repeat (2) @(negedge clk);
    check("R8 falling flag no irq", {8'b0, irq_n}, 9'h001);

    // R9: new rise in the clearing cycle keeps request
    latch(3'b010, 1'b0);
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; det_in = 8'h10;
    @(negedge clk);
    check("R9 set wins over clear", {8'b0, irq_n}, 9'h000);

    // R10: reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 cr0 cleared", {1'b0, cr0_o}, 9'h000);
    check("R10 tone cleared", {1'b0, tone_o}, 9'h000);
    check("R10 irq released", {8'b0, irq_n}, 9'h001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule